// File: doc/BRIEF.md
# MAC Interrupt Status Aggregator

This block gathers single-cycle event pulses from a network MAC into a sticky 16-bit status word and combines it with a 16-bit enable word to drive one level-sensitive interrupt line. Each event owns a fixed bit of the status word. A bit latches on its pulse and stays set until software reads the status word. That read returns the latched value and clears it in the same cycle.

Software reaches the block through a small synchronous register port. A read strobe or a write strobe, an address and write data select either the status word or the enable word. Read data appear on a registered output one cycle after the strobe and hold until the next read. Masking only gates the interrupt line. Pending status survives while its enable bit is zero, so an event that arrived while masked raises the line as soon as its enable bit is written back to one.

Top module: `mac_irq_ctrl`

## Requirements
- R1: Event input bit b latches status bit b on the clock edge where it is high, for the mapped positions b = 0 (rx done), 1 (rx no descriptor), 2 (rx FIFO full), 3 (rx early), 4 (tx done), 7 (tx early), 8 (counter overflow), 9 (link change); mapped mask 0x039F.
- R2: Status bits and enable bits at unmapped positions (mask 0xFC60) are never set and always read as zero, even when pulsed or written with ones.
- R3: A read at address 0 (status) places the status value from before that edge on reg_rdata one cycle later and clears every latched bit.
- R4: An event whose pulse coincides with a status read remains set after the read and is returned by the following read.
- R5: irq is high exactly when some bit is set in both status and enable, and it follows a register change in the same cycle that change becomes visible.
- R6: A write at address 1 loads the enable word (mapped bits only), and a read at address 1 returns it. Writing 0x0000 forces irq low.
- R7: Status bits latch while their enable bit is zero. Writing that enable bit to one raises irq in the cycle after the write.
- R8: Writes at address 0 do not change the status word.
- R9: After reset, status, enable, reg_rdata and irq are all zero.
- R10: reg_rdata holds its last value during cycles without a read. A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 16 | Event pulses, one bit per status position |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Register address: 0 status, 1 enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest corner case is an event that lands on the same edge as a status read. A design that clears without merging new pulses loses that event, and the follow-up read comes back empty. The bench also masks everything, pulses an event, and then re-enables it. An enable that gates the latch rather than the output would never raise irq at that point. Unmapped pulses and all-ones enable writes show whether the fixed bit map leaks extra bits. Writes to the status address and idle cycles after a read catch a status word that software can overwrite and read data that drift between reads.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;

    localparam int REG_W = 16;

    localparam int B_RX_DONE   = 0;
    localparam int B_RX_NODESC = 1;
    localparam int B_RX_FULL   = 2;
    localparam int B_RX_EARLY  = 3;
    localparam int B_TX_DONE   = 4;
    localparam int B_TX_EARLY  = 7;
    localparam int B_CNT_OVF   = 8;
    localparam int B_LINK      = 9;

    function automatic logic [REG_W-1:0] build_map();
        logic [REG_W-1:0] m;
        m = '0;
        m[B_RX_DONE]   = 1'b1;
        m[B_RX_NODESC] = 1'b1;
        m[B_RX_FULL]   = 1'b1;
        m[B_RX_EARLY]  = 1'b1;
        m[B_TX_DONE]   = 1'b1;
        m[B_TX_EARLY]  = 1'b1;
        m[B_CNT_OVF]   = 1'b1;
        m[B_LINK]      = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] EVT_MAP = build_map();

    typedef struct packed {
        logic             rd_stat;
        logic             rd_en;
        logic             rd_any;
        logic             wr_en;
        logic [REG_W-1:0] wdata;
    } reg_cmd_t;

endpackage

// File: rtl/mac_irq_decode.sv
module mac_irq_decode
    import mac_irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output reg_cmd_t          cmd
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);

    always_comb begin
        cmd         = '0;
        cmd.rd_any  = reg_rd;
        cmd.rd_stat = reg_rd && (reg_addr == A_STAT);
        cmd.rd_en   = reg_rd && (reg_addr == A_EN);
        cmd.wr_en   = reg_wr && (reg_addr == A_EN);
        cmd.wdata   = reg_wdata;
    end
endmodule

// File: rtl/mac_irq_status.sv
module mac_irq_status
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt,
    input  logic             clr,
    output logic [REG_W-1:0] status_q
);
    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (EVT_MAP[g]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) bit_q <= 1'b0;
                else     bit_q <= (bit_q && !clr) || evt[g];
            end
            assign status_q[g] = bit_q;
        end else begin : g_tied
            assign status_q[g] = 1'b0;
        end
    end
endmodule

// File: rtl/mac_irq_enable.sv
module mac_irq_enable
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] en_q
);
    for (genvar g = 0; g < REG_W; g++) begin : g_bit
        if (EVT_MAP[g]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)       bit_q <= 1'b0;
                else if (load) bit_q <= wdata[g];
            end
            assign en_q[g] = bit_q;
        end else begin : g_tied
            assign en_q[g] = 1'b0;
        end
    end
endmodule

// File: rtl/mac_irq_rdport.sv
module mac_irq_rdport
    import mac_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  reg_cmd_t         cmd,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] enable,
    output logic [REG_W-1:0] rdata_q
);
    logic [REG_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (cmd.rd_stat)    sel = status;
        else if (cmd.rd_en) sel = enable;
    end

    always_ff @(posedge clk) begin
        if (rst)             rdata_q <= '0;
        else if (cmd.rd_any) rdata_q <= sel;
    end
endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
    import mac_irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0,
    parameter int EN_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  evt_in,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    reg_cmd_t         cmd;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] en_q;

    mac_irq_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
    ) u_dec (
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd(cmd)
    );

    mac_irq_status u_stat (
        .clk(clk), .rst(rst), .evt(evt_in), .clr(cmd.rd_stat),
        .status_q(status_q)
    );

    mac_irq_enable u_en (
        .clk(clk), .rst(rst), .load(cmd.wr_en), .wdata(cmd.wdata),
        .en_q(en_q)
    );

    mac_irq_rdport u_rd (
        .clk(clk), .rst(rst), .cmd(cmd), .status(status_q),
        .enable(en_q), .rdata_q(reg_rdata)
    );

    assign irq = |(status_q & en_q);
endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk
    import mac_irq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_W-1:0]  evt_in,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  status,
    input logic [REG_W-1:0]  enable,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq
);
    logic rd_s;
    logic wr_s;
    logic [REG_W-1:0] ev_m;
    assign rd_s = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));
    assign wr_s = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));
    assign ev_m = evt_in & EVT_MAP;

    // R1
    evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev_m) |=> ((status & $past(ev_m)) == $past(ev_m)));

    // R2
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((status | enable) & ~EVT_MAP) == '0);

    // R3
    read_value_chk: assert property (@(posedge clk) disable iff (rst)
        rd_s |=> (reg_rdata == $past(status)));

    // R3
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_s && ev_m == '0) |=> (status == '0));

    // R4
    read_keep_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_s && |ev_m) |=> (status == $past(ev_m)));

    // R6
    mask_all_chk: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq);

    // R8
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_s && !reg_rd && ev_m == '0) |=> $stable(status));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
    .clk(clk), .rst(rst), .evt_in(evt_in), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .status(status_q), .enable(en_q),
    .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/mac_irq_ctrl_bench.sv
module mac_irq_ctrl_bench;
    localparam logic [15:0] MAP = 16'h039F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] evt_in = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] m_st = '0;
    logic [15:0] m_en = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    mac_irq_ctrl u_mac_irq_ctrl (
        .clk(clk), .rst(rst), .evt_in(evt_in), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one register-port cycle, expected read data go to the scoreboard
    task automatic op(input logic [15:0] evt, input logic rd, input logic wr,
                      input logic [3:0] addr, input logic [15:0] wd, input string tag);
        @(negedge clk);
        evt_in = evt; reg_rd = rd; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        if (rd) begin
            exp_q.push_back(addr == 4'd0 ? m_st : (addr == 4'd1 ? m_en : 16'h0));
            tag_q.push_back(tag);
        end
        @(posedge clk);
        if (rd && addr == 4'd0) m_st = '0;
        m_st = m_st | (evt & MAP);
        if (wr && addr == 4'd1) m_en = wd & MAP;
        #1;
        evt_in = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk_irq(input string tag);
        chk({15'b0, irq}, {15'b0, |(m_st & m_en)}, tag);
    endtask

    // monitor: compare read data one cycle after each read
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: unexpected read data %h expected none", reg_rdata);
            end else begin
                chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R9 reset state
        chk(reg_rdata, 16'h0, "R9 rdata");
        chk({15'b0, irq}, 16'h0, "R9 irq");
        op(16'h0, 1, 0, 4'd0, 16'h0, "R9 status");
        op(16'h0, 1, 0, 4'd1, 16'h0, "R9 enable");

        // R1 each mapped bit, enable everything
        op(16'h0, 0, 1, 4'd1, 16'hFFFF, "R6 wr");
        for (int b = 0; b < 16; b++) begin
            if (MAP[b]) begin
                op(16'h1 << b, 0, 0, 4'd0, 16'h0, "R1 pulse");
                chk_irq("R5 irq on event");
                op(16'h0, 1, 0, 4'd0, 16'h0, "R1 map bit");
                chk_irq("R3 irq after clear");
            end
        end

        // R2 unmapped pulses and enable readback
        op(16'hFC60, 0, 0, 4'd0, 16'h0, "R2 pulse");
        chk_irq("R2 irq");
        op(16'h0, 1, 0, 4'd0, 16'h0, "R2 status");
        op(16'h0, 1, 0, 4'd1, 16'h0, "R2 enable");

        // R4 event coinciding with read
        op(16'h0010, 0, 0, 4'd0, 16'h0, "R4 first");
        op(16'h0001, 1, 0, 4'd0, 16'h0, "R4 read old");
        chk_irq("R4 irq kept");
        op(16'h0, 1, 0, 4'd0, 16'h0, "R4 kept event");

        // R6 / R7 masking keeps pending status
        op(16'h0, 0, 1, 4'd1, 16'h0000, "R6 mask");
        op(16'h0200, 0, 0, 4'd0, 16'h0, "R7 pulse");
        chk_irq("R6 masked irq");
        op(16'h0, 0, 1, 4'd1, 16'h0200, "R7 unmask");
        chk_irq("R7 irq on enable");
        op(16'h0, 1, 0, 4'd1, 16'h0, "R6 enable readback");
        op(16'h0, 1, 0, 4'd0, 16'h0, "R7 pending");
        chk_irq("R3 irq cleared");

        // R5 selective enable
        op(16'h0, 0, 1, 4'd1, 16'h0001, "R5 wr");
        op(16'h0010, 0, 0, 4'd0, 16'h0, "R5 other");
        chk_irq("R5 not enabled");
        op(16'h0001, 0, 0, 4'd0, 16'h0, "R5 own");
        chk_irq("R5 enabled");
        op(16'h0, 1, 0, 4'd0, 16'h0, "R5 status");

        // R8 write to status ignored
        op(16'h0008, 0, 0, 4'd0, 16'h0, "R8 pulse");
        op(16'h0, 0, 1, 4'd0, 16'hFFFF, "R8 wr");
        op(16'h0, 0, 1, 4'd0, 16'h0000, "R8 wr0");
        op(16'h0, 1, 0, 4'd0, 16'h0, "R8 status");

        // R10 hold and other address
        op(16'h0, 0, 0, 4'd0, 16'h0, "R10 idle");
        op(16'h0, 0, 0, 4'd0, 16'h0, "R10 idle");
        chk(reg_rdata, 16'h0008, "R10 hold");
        op(16'h0004, 0, 0, 4'd0, 16'h0, "R10 pulse");
        op(16'h0, 1, 0, 4'd5, 16'h0, "R10 other addr");
        op(16'h0, 1, 0, 4'd0, 16'h0, "R10 status");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule